// File: doc/BRIEF.md
# Timed-Write Protected Debug-Port Control and Reset-Cause Register

This block is an 8-bit control and status register that sits on a simple CPU bus with a write strobe, write data and combinational read data. It holds one control bit that switches off the on-chip test-access (JTAG) port. That bit is guarded by a timed double-write sequence, so that a single errant store cannot switch the port off or back on. Beside it are sticky flags that record the cause of the last reset. One of these flags is set when a reset is requested through the test port's own reset register.

Software reads the flags to learn why the device restarted and clears them by writing zeros. A write of one to a flag leaves it unchanged. To change the port-disable bit, software stores the same new value twice within a short window. The block combines the disable bit with an enable fuse input to produce the port enable.

Top module: `jtag_ctl_reg`

## Requirements
- R1: `jtagEn` equals `fuseEn` AND NOT the port-disable bit, which is bit 7 of the register (0 = port enabled, 1 = port disabled).
- R2: Bit 7 takes a new value only when two writes carry the same bit-7 value and the second comes 1 to WINDOW cycles after the first (WINDOW = 4 by default). It changes in the cycle after the second write.
- R3: The pending value is dropped if the write that follows the first carries a different bit-7 value. It is also dropped if no write arrives within WINDOW cycles. A later write then starts a new sequence.
- R4: After power-on reset, `rdData` reads 8'h01 and `jtagEn` follows `fuseEn`.
- R5: A pulse on `jtagRstEvt` sets bit 4. Pulses on `extRstEvt`, `bodRstEvt` and `wdtRstEvt` set bits 1, 2 and 3. Each flag is visible the cycle after its pulse.
- R6: A write with 0 in a flag bit clears that flag in the next cycle, unless the flag's event pulses in the same cycle. In that case the flag stays set.
- R7: A write with 1 in a flag bit leaves that flag unchanged.
- R8: Bits 6 and 5 always read 0, whatever is written.
- R9: Power-on reset sets bit 0. A write of 0 to bit 0 clears it, and it stays clear until the next power-on reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstPorN | input | 1 | Power-on reset, active low, asynchronous |
| wrEn | input | 1 | Bus write strobe |
| wrData | input | 8 | Bus write data |
| rdData | output | 8 | Register contents |
| extRstEvt | input | 1 | External reset event pulse |
| bodRstEvt | input | 1 | Brown-out reset event pulse |
| wdtRstEvt | input | 1 | Watchdog reset event pulse |
| jtagRstEvt | input | 1 | Test-port reset register event pulse |
| fuseEn | input | 1 | Port enable fuse (1 = programmed) |
| jtagEn | output | 1 | Port enable |

## Verification
The bench builds the block with the default WINDOW of 4, so the counter is 3 bits wide. At that size every gap between a first and a second write can be swept, from 1 to 7 cycles, for both start values and both target values. This covers both sides of the window edge and the re-arm after expiry. Mismatch cancellation, every flag source, the event-versus-clear collision and all fuse and disable combinations are checked exhaustively. Expected values are computed from the gap arithmetic.

// File: rtl/jtag_ctl_pkg.sv
package jtag_ctl_pkg;
  localparam int DATA_W  = 8;
  localparam int FLAG_N  = 5;
  localparam int DIS_BIT = 7;

  typedef struct packed {
    logic              commit;
    logic              commitVal;
    logic [FLAG_N-1:0] clrMask;
  } regStrobeT;
endpackage

// File: rtl/jtag_ctl_seq.sv
module jtag_ctl_seq
  import jtag_ctl_pkg::*;
#(
  parameter int WINDOW = 4
) (
  input  logic              clk,
  input  logic              rstPorN,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  output regStrobeT         strobe
);
  localparam int CNT_W = $clog2(WINDOW + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(WINDOW);

  logic [CNT_W-1:0] winCnt;
  logic             pendVal;
  logic             armed;
  logic             match;

  assign armed = (winCnt != '0);
  assign match = armed && (wrData[DIS_BIT] == pendVal);

  always_ff @(posedge clk or negedge rstPorN) begin
    if (!rstPorN) begin
      winCnt  <= '0;
      pendVal <= 1'b0;
    end else if (wrEn) begin
      if (!armed) begin
        winCnt  <= CNT_LOAD;
        pendVal <= wrData[DIS_BIT];
      end else begin
        winCnt  <= '0;
      end
    end else if (armed) begin
      winCnt <= winCnt - 1'b1;
    end
  end

  always_comb begin
    strobe.commit    = wrEn && match;
    strobe.commitVal = pendVal;
    strobe.clrMask   = wrEn ? ~wrData[FLAG_N-1:0] : '0;
  end
endmodule

// File: rtl/jtag_ctl_dp.sv
module jtag_ctl_dp
  import jtag_ctl_pkg::*;
(
  input  logic              clk,
  input  logic              rstPorN,
  input  regStrobeT         strobe,
  input  logic [FLAG_N-1:0] evtVec,
  input  logic              fuseEn,
  output logic [DATA_W-1:0] rdData,
  output logic              jtagEn
);
  localparam int PAD_W = DIS_BIT - FLAG_N;

  logic              disBit;
  logic [FLAG_N-1:0] flags;

  always_ff @(posedge clk or negedge rstPorN) begin
    if (!rstPorN) begin
      disBit <= 1'b0;
      flags  <= FLAG_N'(1);
    end else begin
      if (strobe.commit) disBit <= strobe.commitVal;
      flags <= (flags & ~strobe.clrMask) | evtVec;
    end
  end

  assign rdData = {disBit, {PAD_W{1'b0}}, flags};
  assign jtagEn = fuseEn & ~disBit;
endmodule

// File: rtl/jtag_ctl_reg.sv
module jtag_ctl_reg
  import jtag_ctl_pkg::*;
#(
  parameter int WINDOW = 4
) (
  input  logic       clk,
  input  logic       rstPorN,
  input  logic       wrEn,
  input  logic [7:0] wrData,
  output logic [7:0] rdData,
  input  logic       extRstEvt,
  input  logic       bodRstEvt,
  input  logic       wdtRstEvt,
  input  logic       jtagRstEvt,
  input  logic       fuseEn,
  output logic       jtagEn
);
  regStrobeT         strobe;
  logic [FLAG_N-1:0] evtVec;

  assign evtVec = {jtagRstEvt, wdtRstEvt, bodRstEvt, extRstEvt, 1'b0};

  jtag_ctl_seq #(.WINDOW(WINDOW)) u_seq (
    .clk(clk), .rstPorN(rstPorN), .wrEn(wrEn), .wrData(wrData), .strobe(strobe)
  );

  jtag_ctl_dp u_dp (
    .clk(clk), .rstPorN(rstPorN), .strobe(strobe), .evtVec(evtVec),
    .fuseEn(fuseEn), .rdData(rdData), .jtagEn(jtagEn)
  );
endmodule

// File: rtl/jtag_ctl_reg_chk.sv
module jtag_ctl_reg_chk (
  input logic       clk,
  input logic       rstPorN,
  input logic       wrEn,
  input logic [7:0] wrData,
  input logic [7:0] rdData,
  input logic       jtagRstEvt,
  input logic       fuseEn,
  input logic       jtagEn
);
  AST_DISABLED_NO_PORT: assert property (@(posedge clk) disable iff (!rstPorN)
    rdData[7] |-> !jtagEn); // R1
  AST_FUSE_OFF_NO_PORT: assert property (@(posedge clk) disable iff (!rstPorN)
    !fuseEn |-> !jtagEn); // R1
  AST_DIS_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rstPorN)
    !wrEn |=> $stable(rdData[7])); // R2
  AST_JTAG_FLAG_SET: assert property (@(posedge clk) disable iff (!rstPorN)
    jtagRstEvt |=> rdData[4]); // R5
  AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rstPorN)
    (wrEn && !wrData[4] && !jtagRstEvt) |=> !rdData[4]); // R6
  AST_FLAG_KEEP_ONE: assert property (@(posedge clk) disable iff (!rstPorN)
    (wrEn && wrData[4] && rdData[4]) |=> rdData[4]); // R7
  AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rstPorN)
    rdData[6:5] == 2'b00); // R8
endmodule

bind jtag_ctl_reg jtag_ctl_reg_chk u_chk (
  .clk(clk), .rstPorN(rstPorN), .wrEn(wrEn), .wrData(wrData), .rdData(rdData),
  .jtagRstEvt(jtagRstEvt), .fuseEn(fuseEn), .jtagEn(jtagEn)
);

// File: tb/jtag_ctl_reg_bench.sv
module jtag_ctl_reg_bench;
  localparam int WIN = 4;

  logic       clk = 1'b0;
  logic       rstPorN = 1'b0;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic [7:0] rdData;
  logic       extRstEvt = 1'b0, bodRstEvt = 1'b0, wdtRstEvt = 1'b0, jtagRstEvt = 1'b0;
  logic       fuseEn = 1'b1;
  logic       jtagEn;
  int         errs = 0;
  int         checks = 0;
  bit         done = 1'b0;

  always #2 clk = ~clk;

  jtag_ctl_reg #(.WINDOW(WIN)) u_jtag_ctl_reg (
    .clk(clk), .rstPorN(rstPorN), .wrEn(wrEn), .wrData(wrData), .rdData(rdData),
    .extRstEvt(extRstEvt), .bodRstEvt(bodRstEvt), .wdtRstEvt(wdtRstEvt),
    .jtagRstEvt(jtagRstEvt), .fuseEn(fuseEn), .jtagEn(jtagEn)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] d);
    wrEn = 1'b1; wrData = d;
    @(negedge clk);
    wrEn = 1'b0; wrData = 8'h00;
  endtask

  task automatic por();
    rstPorN = 1'b0;
    idle(2);
    rstPorN = 1'b1;
    idle(1);
  endtask

  task automatic pulse(input int which);
    {jtagRstEvt, wdtRstEvt, bodRstEvt, extRstEvt} = 4'(1 << which);
    @(negedge clk);
    {jtagRstEvt, wdtRstEvt, bodRstEvt, extRstEvt} = 4'h0;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    por();
    // R4 reset state
    check("R4 reset read", rdData, 8'h01);
    check("R4 reset enable", {7'h0, jtagEn}, 8'h01);

    // R2 / R3 gap sweep: start, target, gap
    for (int s = 0; s < 2; s++)
      for (int v = 0; v < 2; v++)
        for (int g = 1; g <= WIN + 3; g++) begin
          logic expBit;
          por();
          if (s == 1) begin wr(8'h9F); wr(8'h9F); idle(WIN + 2); end
          wr({v[0], 7'h1F});
          idle(g - 1);
          wr({v[0], 7'h1F});
          expBit = (g <= WIN) ? v[0] : s[0];
          check("R2 timed commit", {7'h0, rdData[7]}, {7'h0, expBit});
          idle(WIN + 2);
          check("R3 no late change", {7'h0, rdData[7]}, {7'h0, expBit});
        end

    // R3 mismatch cancels: v, ~v, v leaves start value
    for (int v = 0; v < 2; v++) begin
      por();
      if (v == 0) begin wr(8'h9F); wr(8'h9F); idle(WIN + 2); end
      wr({v[0], 7'h1F});
      wr({~v[0], 7'h1F});
      wr({v[0], 7'h1F});
      idle(WIN + 2);
      check("R3 mismatch cancel", {7'h0, rdData[7]}, {7'h0, ~v[0]});
    end

    // R1 enable from fuse and disable bit
    for (int d = 0; d < 2; d++)
      for (int f = 0; f < 2; f++) begin
        por();
        if (d == 1) begin wr(8'h9F); wr(8'h9F); end
        fuseEn = f[0];
        idle(1);
        check("R1 enable", {7'h0, jtagEn}, {7'h0, f[0] & ~d[0]});
      end
    fuseEn = 1'b1;

    // R5 event flags, R7 write-one keeps, R6 write-zero clears
    for (int k = 0; k < 4; k++) begin
      logic [7:0] bitK;
      bitK = 8'(2 << k);
      por();
      pulse(k);
      check("R5 flag set", rdData, 8'h01 | bitK);
      wr(8'h1F);
      idle(1);
      check("R7 write one keeps", rdData, 8'h01 | bitK);
      wr(8'h1F & ~bitK);
      idle(1);
      check("R6 write zero clears", rdData, 8'h01);
    end

    // R6 event wins over same-cycle clear
    por();
    jtagRstEvt = 1'b1; wrEn = 1'b1; wrData = 8'h00;
    @(negedge clk);
    jtagRstEvt = 1'b0; wrEn = 1'b0;
    check("R6 event beats clear", rdData, 8'h10);

    // R9 power-on flag clear and stay clear
    por();
    wr(8'h1E);
    idle(3);
    check("R9 por flag cleared", rdData, 8'h00);
    por();
    check("R9 por flag set again", rdData, 8'h01);

    // R8 reserved bits read zero
    wr(8'h7F);
    idle(1);
    check("R8 reserved zero", rdData & 8'h60, 8'h00);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule